// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the slave side of a parallel NOR flash bus. It interprets the classic multi-cycle unlock command protocol. Each bus write carries a byte address and a data byte. The byte address is scaled to a word offset according to the bus width of 1, 2 or 4 bytes. The block tracks which step of a command sequence it has reached and reports which read mode the bus should currently see: plain array data, identification, status, or the CFI query table.

The block executes program and erase operations on an internal array of byte-wide words.

- **Program** is a read-modify-write that can only clear bits.
- **Sector erase** and **chip erase** walk their word range at one word per clock and hold `busy` high until the range is all-ones.
- **Unlock bypass** lets a host issue repeated commands without repeating the unlock pair.

A separate read port returns array contents with one cycle of latency. A host uses the `rd_mode` output to steer its read multiplexer.

Top module: `nor_cmd_seq`

## Requirements
- R1: After a synchronous reset the block is idle, `rd_mode` is 0 (array) and `busy` is 0.
- R2: From idle, data 0x98 at word offset 0x55 sets `rd_mode` to 3 (query) on the edge that accepts the write. Any following write returns `rd_mode` to 0.
- R3: The unlock sequence has three cycles. It is 0xAA at unlock offset A, then 0x55 at unlock offset B, then a command byte at offset A. Command 0x90 gives `rd_mode` 1 (identification) and 0xA0 gives `rd_mode` 2 (status, program pending). A wrong byte or offset in any of these cycles, or an unknown command byte, returns the block to idle with `rd_mode` 0.
- R4: The write after a program command stores the old word ANDed with the data byte, so bits can only be cleared. `busy` is high for exactly one cycle, and `rd_mode` then returns to 0.
- R5: Data 0xF0 aborts to idle and clears bypass in every step except two: the program data cycle, where 0xF0 is programmed as data, and a running erase.
- R6: Command 0x80 followed by a second unlock pair and then 0x10 at offset A starts a chip erase. Every word becomes 0xFF, `busy` stays high for exactly the number of array words, and `rd_mode` is 2 during the erase and 0 after it.
- R7: In the same erase sequence, 0x30 at any address erases only the sector containing that address. `busy` stays high for exactly the sector word count, and other sectors keep their data.
- R8: 0x10 at any offset other than A in the erase command cycle aborts to idle. Nothing is erased and `busy` stays 0.
- R9: Every write that arrives while `busy` is high is ignored, including 0xF0 and 0x98.
- R10: Command 0x20 enters bypass. In bypass the command cycle accepts any address with no unlock pair, and after each program the block returns directly to the command cycle.
- R11: Bypass is left by any write in identification mode other than a query entry (for example 0x00), and by 0xF0. Afterwards a lone 0xA0 no longer starts a program.
- R12: The word offset is the byte address shifted right by log2 of the bus width. Unlock and query offsets are compared against that word offset modulo the sector size.
- R13: In identification mode, 0x98 at word offset 0x55 enters query mode (`rd_mode` 3). Any other write returns to idle.
- R14: `rd_data` shows the array word at the scaled `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | BA_W | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_addr | input | BA_W | Byte address for array read |
| rd_data | output | 8 | Array word read, one cycle latency |
| rd_mode | output | 2 | 0 array, 1 identification, 2 status, 3 query |
| busy | output | 1 | Program or erase in progress |

## Verification
A step register that holds the wrong value shows up at `rd_mode` on the very next accepted write, because every accepted write updates the mode on its own edge. The bench therefore samples the mode after each write of long command scripts. A wrong bypass flag or a wrong erase range is invisible until the following command or until a read. For that reason, each erase is followed by a count of `busy` cycles and by reads both inside and outside the target range. Each bypass case ends with a bare 0xA0 whose resulting mode reveals whether bypass is still held.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_CMD,
    ST_PROG,
    ST_PGM,
    ST_AUTO,
    ST_EU0,
    ST_EU1,
    ST_ECMD,
    ST_ERASE,
    ST_CFI
  } seq_state_e;

  localparam logic [1:0] RM_ARRAY  = 2'd0;
  localparam logic [1:0] RM_IDENT  = 2'd1;
  localparam logic [1:0] RM_STATUS = 2'd2;
  localparam logic [1:0] RM_QUERY  = 2'd3;

  localparam logic [7:0] D_UNLK_A  = 8'hAA;
  localparam logic [7:0] D_UNLK_B  = 8'h55;
  localparam logic [7:0] D_RESET   = 8'hF0;
  localparam logic [7:0] D_QUERY   = 8'h98;
  localparam logic [7:0] D_BYPASS  = 8'h20;
  localparam logic [7:0] D_ERSETUP = 8'h80;
  localparam logic [7:0] D_IDENT   = 8'h90;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_CHIP    = 8'h10;
  localparam logic [7:0] D_SECT    = 8'h30;

  function automatic logic [1:0] mode_of(seq_state_e s);
    case (s)
      ST_AUTO:  return RM_IDENT;
      ST_PROG,
      ST_PGM,
      ST_ERASE: return RM_STATUS;
      ST_CFI:   return RM_QUERY;
      default:  return RM_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_array.sv
module nor_seq_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/nor_seq_eraser.sv
module nor_seq_eraser #(
  parameter int ARR_AW  = 10,
  parameter int SECT_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic                      chip,
  input  logic [ARR_AW-SECT_AW-1:0] sect,
  output logic                      we,
  output logic [ARR_AW-1:0]         idx,
  output logic                      fin
);
  localparam int SIDX_W = ARR_AW - SECT_AW;

  logic              active_q;
  logic [ARR_AW-1:0] ptr_q;
  logic [ARR_AW-1:0] last_q;

  assign we  = active_q;
  assign idx = ptr_q;
  assign fin = active_q && (ptr_q == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      last_q   <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      if (chip) begin
        ptr_q  <= '0;
        last_q <= '1;
      end else begin
        ptr_q  <= {sect, {SECT_AW{1'b0}}};
        last_q <= {sect, {SECT_AW{1'b1}}};
      end
    end else if (active_q) begin
      if (fin) active_q <= 1'b0;
      else     ptr_q    <= ptr_q + 1'b1;
    end
  end

  AST_ERS_STEP: assert property (@(posedge clk) disable iff (rst)
    (active_q && !fin && !go) |=> (active_q && ptr_q == $past(ptr_q) + 1'b1)); // R6

  AST_ERS_SECT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (go && !chip) |=> (ptr_q[SECT_AW-1:0] == '0 && ptr_q[ARR_AW-1:SECT_AW] == $past(sect))); // R7

  logic [SIDX_W-1:0] unused_w;
  assign unused_w = '0;

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_seq_pkg::*;
#(
  parameter int ARR_AW    = 10,
  parameter int SECT_AW   = 8,
  parameter int UNLOCK0   = 'h55,
  parameter int UNLOCK1   = 'hAA,
  parameter int QUERY_OFF = 'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ARR_AW-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              ers_fin,
  output logic [1:0]        mode,
  output logic              busy,
  output logic              ers_go,
  output logic              ers_chip,
  output logic              pgm_active,
  output logic [ARR_AW-1:0] pgm_idx,
  output logic [7:0]        pgm_val
);
  localparam logic [SECT_AW-1:0] U0 = SECT_AW'(UNLOCK0);
  localparam logic [SECT_AW-1:0] U1 = SECT_AW'(UNLOCK1);
  localparam logic [SECT_AW-1:0] QO = SECT_AW'(QUERY_OFF);

  seq_state_e        state_q, state_d;
  logic              byp_q, byp_d;
  logic [1:0]        mode_q;
  logic              busy_q;
  logic [ARR_AW-1:0] pgm_idx_q;
  logic [7:0]        pgm_val_q;
  logic              pgm_go;
  logic              abort;
  logic [SECT_AW-1:0] off;

  assign off        = wr_idx[SECT_AW-1:0];
  assign mode       = mode_q;
  assign busy       = busy_q;
  assign pgm_active = (state_q == ST_PGM);
  assign pgm_idx    = pgm_idx_q;
  assign pgm_val    = pgm_val_q;

  always_comb begin
    state_d  = state_q;
    byp_d    = byp_q;
    ers_go   = 1'b0;
    ers_chip = 1'b0;
    pgm_go   = 1'b0;
    abort    = 1'b0;
    if (state_q == ST_ERASE) begin
      if (ers_fin) state_d = byp_q ? ST_CMD : ST_IDLE;
    end else if (state_q == ST_PGM) begin
      state_d = byp_q ? ST_CMD : ST_IDLE;
    end else if (wr_en) begin
      if (wr_data == D_RESET && state_q != ST_PROG) begin
        abort = 1'b1;
      end else begin
        case (state_q)
          ST_IDLE, ST_EU0: begin
            if (off == QO && wr_data == D_QUERY)       state_d = ST_CFI;
            else if (off == U0 && wr_data == D_UNLK_A) state_d = (state_q == ST_IDLE) ? ST_UNLK1 : ST_EU1;
            else                                       abort = 1'b1;
          end
          ST_UNLK1, ST_EU1: begin
            if (off == U1 && wr_data == D_UNLK_B) state_d = (state_q == ST_UNLK1) ? ST_CMD : ST_ECMD;
            else                                  abort = 1'b1;
          end
          ST_CMD: begin
            if (!byp_q && off != U0) abort = 1'b1;
            else begin
              case (wr_data)
                D_BYPASS:  byp_d   = 1'b1;
                D_ERSETUP: state_d = ST_EU0;
                D_IDENT:   state_d = ST_AUTO;
                D_PROG:    state_d = ST_PROG;
                default:   abort   = 1'b1;
              endcase
            end
          end
          ST_PROG: begin
            pgm_go  = 1'b1;
            state_d = ST_PGM;
          end
          ST_AUTO: begin
            if (off == QO && wr_data == D_QUERY) state_d = ST_CFI;
            else                                 abort = 1'b1;
          end
          ST_ECMD: begin
            if (wr_data == D_CHIP && off == U0) begin
              ers_go   = 1'b1;
              ers_chip = 1'b1;
              state_d  = ST_ERASE;
            end else if (wr_data == D_SECT) begin
              ers_go  = 1'b1;
              state_d = ST_ERASE;
            end else begin
              abort = 1'b1;
            end
          end
          default: abort = 1'b1;
        endcase
      end
      if (abort) begin
        state_d = ST_IDLE;
        byp_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      byp_q     <= 1'b0;
      mode_q    <= RM_ARRAY;
      busy_q    <= 1'b0;
      pgm_idx_q <= '0;
      pgm_val_q <= '0;
    end else begin
      state_q <= state_d;
      byp_q   <= byp_d;
      mode_q  <= mode_of(state_d);
      busy_q  <= (state_d == ST_PGM) || (state_d == ST_ERASE);
      if (pgm_go) begin
        pgm_idx_q <= wr_idx;
        pgm_val_q <= wr_data;
      end
    end
  end

  AST_QUERY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && state_q == ST_IDLE && off == QO && wr_data == D_QUERY) |=> (mode_q == RM_QUERY)); // R2

  AST_RESET_ABORT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == D_RESET && !(state_q inside {ST_PROG, ST_PGM, ST_ERASE}))
    |=> (state_q == ST_IDLE && !byp_q && mode_q == RM_ARRAY)); // R5

  AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE && !ers_fin) |=> (state_q == ST_ERASE && busy_q)); // R9

  AST_BYPASS_RETURN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PGM && byp_q) |=> (state_q == ST_CMD && mode_q == RM_ARRAY)); // R10

  AST_CHIP_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && state_q == ST_ECMD && wr_data == D_CHIP && off != U0) |=> (!busy_q && state_q == ST_IDLE)); // R8

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int BUS_BYTES    = 2,
  parameter int SECTOR_WORDS = 256,
  parameter int NUM_SECTORS  = 4,
  parameter int UNLOCK0      = 'h55,
  parameter int UNLOCK1      = 'hAA,
  parameter int QUERY_OFF    = 'h55,
  localparam int BSHIFT      = $clog2(BUS_BYTES),
  localparam int ARR_AW      = $clog2(SECTOR_WORDS * NUM_SECTORS),
  localparam int BA_W        = ARR_AW + BSHIFT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [BA_W-1:0] wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [BA_W-1:0] rd_addr,
  output logic [7:0]      rd_data,
  output logic [1:0]      rd_mode,
  output logic            busy
);
  localparam int SECT_AW = $clog2(SECTOR_WORDS);

  logic [ARR_AW-1:0] wr_idx;
  logic [ARR_AW-1:0] rd_idx;
  logic              ers_go, ers_chip, ers_we, ers_fin;
  logic [ARR_AW-1:0] ers_idx;
  logic              pgm_active;
  logic [ARR_AW-1:0] pgm_idx;
  logic [7:0]        pgm_val;
  logic [ARR_AW-1:0] a_addr;
  logic              a_we;
  logic [7:0]        a_wdata, a_rdata;

  assign wr_idx = wr_addr[BA_W-1:BSHIFT];
  assign rd_idx = rd_addr[BA_W-1:BSHIFT];

  generate
    if (BSHIFT > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^{wr_addr[BSHIFT-1:0], rd_addr[BSHIFT-1:0]};
    end
  endgenerate

  nor_seq_fsm #(
    .ARR_AW(ARR_AW), .SECT_AW(SECT_AW),
    .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1), .QUERY_OFF(QUERY_OFF)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ers_fin(ers_fin), .mode(rd_mode), .busy(busy), .ers_go(ers_go),
    .ers_chip(ers_chip), .pgm_active(pgm_active), .pgm_idx(pgm_idx), .pgm_val(pgm_val)
  );

  nor_seq_eraser #(.ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_ers (
    .clk(clk), .rst(rst), .go(ers_go), .chip(ers_chip),
    .sect(wr_idx[ARR_AW-1:SECT_AW]), .we(ers_we), .idx(ers_idx), .fin(ers_fin)
  );

  always_comb begin
    if (ers_we)          a_addr = ers_idx;
    else if (pgm_active) a_addr = pgm_idx;
    else                 a_addr = wr_idx;
    a_we    = ers_we | pgm_active;
    a_wdata = ers_we ? 8'hFF : (a_rdata & pgm_val);
  end

  nor_seq_array #(.AW(ARR_AW), .DW(8)) u_mem (
    .clk(clk), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(rd_idx), .b_rdata(rd_data)
  );

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(ers_we && pgm_active)); // R9

  AST_BUSY_COVERS_ERASE: assert property (@(posedge clk) disable iff (rst)
    (ers_we && !ers_fin) |-> busy); // R6

endmodule

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [10:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [1:0]  rd_mode;
  logic        busy;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nor_cmd_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_mode(rd_mode), .busy(busy)
  );

  typedef struct packed {
    logic [10:0] a;
    logic [7:0]  d;
    logic [1:0]  m;
    logic [3:0]  r;
  } vec_t;

  // byte 0x0AA = word 0x55 (offset A), byte 0x154 = word 0xAA (offset B)
  localparam vec_t TBL [0:26] = '{
    '{11'h0AA, 8'h98, 2'd3, 4'd2},  // R2 query entry
    '{11'h000, 8'h12, 2'd0, 4'd2},  // R2 leave query
    '{11'h0AA, 8'hAA, 2'd0, 4'd3},
    '{11'h154, 8'h55, 2'd0, 4'd3},
    '{11'h0AA, 8'h90, 2'd1, 4'd3},  // R3 identification
    '{11'h0AA, 8'h98, 2'd3, 4'd13}, // R13 query from identification
    '{11'h000, 8'hF0, 2'd0, 4'd5},  // R5 abort
    '{11'h0AA, 8'hAA, 2'd0, 4'd3},
    '{11'h154, 8'h55, 2'd0, 4'd3},
    '{11'h000, 8'h90, 2'd0, 4'd3},  // R3 command at wrong offset
    '{11'h0AA, 8'hAA, 2'd0, 4'd3},
    '{11'h0AA, 8'h55, 2'd0, 4'd3},  // R3 second cycle at wrong offset
    '{11'h0AA, 8'h90, 2'd0, 4'd3},  // R3 now idle, no command
    '{11'h055, 8'h98, 2'd0, 4'd12}, // R12 byte 0x55 is word 0x2A
    '{11'h0AB, 8'h98, 2'd3, 4'd12}, // R12 byte 0xAB is word 0x55
    '{11'h100, 8'h00, 2'd0, 4'd2},
    '{11'h2AA, 8'hAA, 2'd0, 4'd12}, // R12 word 0x155 mod 256
    '{11'h154, 8'h55, 2'd0, 4'd12},
    '{11'h2AA, 8'h90, 2'd1, 4'd12},
    '{11'h000, 8'hF0, 2'd0, 4'd5},
    '{11'h0AA, 8'hAA, 2'd0, 4'd3},
    '{11'h154, 8'h55, 2'd0, 4'd3},
    '{11'h0AA, 8'h33, 2'd0, 4'd3},  // R3 unknown command
    '{11'h0AA, 8'hAA, 2'd0, 4'd3},
    '{11'h154, 8'h55, 2'd0, 4'd3},
    '{11'h0AA, 8'h90, 2'd1, 4'd3},
    '{11'h0AA, 8'h42, 2'd0, 4'd13}  // R13 other write leaves identification
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic unlock();
    wr(11'h0AA, 8'hAA);
    wr(11'h154, 8'h55);
  endtask

  task automatic busy_wait(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode", rd_mode, 0);
    chk("R1 busy", busy, 0);

    for (int i = 0; i < 27; i++) begin
      wr(TBL[i].a, TBL[i].d);
      chk($sformatf("R%0d table step %0d", TBL[i].r, i), rd_mode, TBL[i].m);
    end

    // R6 chip erase
    unlock(); wr(11'h0AA, 8'h80); unlock(); wr(11'h0AA, 8'h10);
    chk("R6 mode during erase", rd_mode, 2);
    busy_wait(n);
    chk("R6 busy cycles", n, 1024);
    chk("R6 mode after", rd_mode, 0);
    rd(11'h000, v); chk("R6 word 0", v, 8'hFF);
    rd(11'h7FE, v); chk("R14 last word", v, 8'hFF);

    // R4 program
    unlock(); wr(11'h0AA, 8'hA0);
    chk("R3 status mode", rd_mode, 2);
    wr(11'h020, 8'h5A);
    chk("R4 busy during program", busy, 1);
    @(negedge clk);
    chk("R4 busy after", busy, 0);
    chk("R4 mode after", rd_mode, 0);
    rd(11'h020, v); chk("R4 programmed", v, 8'h5A);
    unlock(); wr(11'h0AA, 8'hA0);
    wr(11'h020, 8'hF0);
    chk("R5 F0 as data keeps status", rd_mode, 2);
    rd(11'h020, v); chk("R5 F0 programmed", v, 8'h50);
    unlock(); wr(11'h0AA, 8'hA0); wr(11'h020, 8'hFF);
    rd(11'h020, v); chk("R4 no bit rises", v, 8'h50);

    // R7 sector erase
    unlock(); wr(11'h0AA, 8'hA0); wr(11'h200, 8'h11);
    rd(11'h200, v); chk("R4 sector1 word", v, 8'h11);
    unlock(); wr(11'h0AA, 8'h80); unlock(); wr(11'h210, 8'h30);
    busy_wait(n);
    chk("R7 busy cycles", n, 256);
    rd(11'h200, v); chk("R7 erased", v, 8'hFF);
    rd(11'h020, v); chk("R7 other sector kept", v, 8'h50);

    // R8 chip erase at wrong offset
    unlock(); wr(11'h0AA, 8'h80); unlock(); wr(11'h000, 8'h10);
    chk("R8 mode", rd_mode, 0);
    chk("R8 busy", busy, 0);
    rd(11'h020, v); chk("R8 not erased", v, 8'h50);

    // R10 bypass
    unlock(); wr(11'h0AA, 8'h20);
    chk("R10 bypass entry mode", rd_mode, 0);
    wr(11'h000, 8'hA0);
    chk("R10 command any address", rd_mode, 2);
    wr(11'h040, 8'h3C);
    @(negedge clk);
    wr(11'h100, 8'hA0);
    chk("R10 back to command cycle", rd_mode, 2);
    wr(11'h042, 8'hC3);
    rd(11'h040, v); chk("R10 first program", v, 8'h3C);
    rd(11'h042, v); chk("R10 second program", v, 8'hC3);

    // R11 leave bypass from identification
    wr(11'h000, 8'h90);
    chk("R11 identification", rd_mode, 1);
    wr(11'h000, 8'h00);
    chk("R11 leave", rd_mode, 0);
    wr(11'h000, 8'hA0);
    chk("R11 bare command rejected", rd_mode, 0);

    // R9 writes ignored while erasing, bypass kept
    unlock(); wr(11'h0AA, 8'h20);
    wr(11'h000, 8'h80); unlock(); wr(11'h040, 8'h30);
    chk("R9 erase started", busy, 1);
    wr(11'h000, 8'hF0);
    wr(11'h0AA, 8'h98);
    chk("R9 mode still status", rd_mode, 2);
    busy_wait(n);
    chk("R9 mode after erase", rd_mode, 0);
    wr(11'h000, 8'hA0);
    chk("R9 bypass survived", rd_mode, 2);
    wr(11'h060, 8'h00);
    rd(11'h060, v); chk("R9 program after erase", v, 8'h00);
    rd(11'h040, v); chk("R9 erased word", v, 8'hFF);
    wr(11'h000, 8'hF0);
    wr(11'h000, 8'hA0);
    chk("R11 F0 clears bypass", rd_mode, 0);

    // R1 reset again
    wr(11'h0AA, 8'h98);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mode after reset", rd_mode, 0);

    finish_run();
  end
endmodule